// File: doc/BRIEF.md
# Serial Port Data Buffer with Status Flags

This block sits between a processor register bus and the serial shift engines of an asynchronous serial port. One bus address, the data address, reaches two different stores. A write goes to a single-entry transmit holding buffer. A read takes the oldest character out of a small receive FIFO, which is two entries deep by default. A second address, the status address, returns the receive-complete, transmit-complete, holding-empty and overrun flags. Reading the status address has no side effects.

The transmit side hands characters to an external shift engine. It raises a one-cycle load strobe whenever the holding buffer is full, the transmitter is enabled and the engine reports that it is empty. The receive side takes characters from an external receive engine through a push strobe. A two-bit character-size field selects 5, 6, 7 or 8 data bits. Each of the three main flags raises an interrupt request when its enable input is high.

Top module: `uart_data_buffer`

## Requirements
- R1: A bus write with `bus_addr`=0 goes to the transmit holding buffer. A bus read with `bus_addr`=0 returns the oldest unread receive character on `bus_rdata` in the same cycle.
- R2: Each bus read with `bus_addr`=0 removes one receive character, and characters come out in arrival order. A read while the FIFO is empty returns 0 and changes nothing.
- R3: The character size is set by `char_size`: 0 selects 5 bits, 1 selects 6, 2 selects 7 and 3 selects 8. Data bits above the selected size are zero on `txs_data` and zero on data reads.
- R4: A data write while the holding-empty flag is 0 is discarded, and the held character does not change.
- R5: While the holding buffer is full, `tx_en` is 1 and `txs_empty` is 1, `txs_load` is high with the held character on `txs_data`. The holding-empty flag reads 1 from the next cycle.
- R6: Receive-complete is 1 exactly when the FIFO holds at least one character. While `rx_en` is 0 the FIFO is emptied within one clock, and pushes are ignored.
- R7: Transmit-complete becomes 1 in the cycle after a `txs_done` pulse that arrives while the holding buffer is empty. It clears after a status-address write with data bit 6 set, or after a `txc_ack` pulse. When a set and a clear fall in the same cycle, the set wins.
- R8: After reset the holding-empty flag is 1, and receive-complete, transmit-complete and overrun are 0.
- R9: `irq_rxc`, `irq_txc` and `irq_dre` are each the matching flag ANDed with its enable input.
- R10: A push while the FIFO is full, with no data read in the same cycle, drops the new character and sets the overrun flag. The next data read clears the overrun flag. A push and a data read in the same cycle on a full FIFO keep the new character.
- R11: A read with `bus_addr`=1 returns receive-complete in bit 7, transmit-complete in bit 6, holding-empty in bit 5 and overrun in bit 3, with the other bits 0. This read changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 1 | 0 = data address, 1 = status address |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Bus read data (combinational) |
| char_size | input | 2 | Character size, 0..3 for 5..8 bits |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable; low flushes the FIFO |
| rxc_ie | input | 1 | Receive-complete interrupt enable |
| txc_ie | input | 1 | Transmit-complete interrupt enable |
| dre_ie | input | 1 | Holding-empty interrupt enable |
| txc_ack | input | 1 | Transmit-complete interrupt acknowledge |
| txs_empty | input | 1 | Transmit shift engine is empty |
| txs_done | input | 1 | Transmit shift engine finished a frame |
| txs_load | output | 1 | Load strobe to the transmit shift engine |
| txs_data | output | 8 | Character for the transmit shift engine |
| rx_push | input | 1 | Receive engine has a new character |
| rx_data | input | 8 | Received character |
| irq_rxc | output | 1 | Receive-complete interrupt request |
| irq_txc | output | 1 | Transmit-complete interrupt request |
| irq_dre | output | 1 | Holding-empty interrupt request |

## Verification
Two collisions get directed attention. The first is a push from the receive engine landing in the same cycle as a data read on a full FIFO. The bench drives `rx_push` and `bus_rd` together and checks three things: the head value returned, the overrun flag staying clear, and the order of the two characters that remain. The second is a frame-done pulse coinciding with a transmit-complete acknowledge. The bench drives both in one cycle and expects the flag to read 1 on the next status read.

// File: rtl/uart_buf_pkg.sv
package uart_buf_pkg;

  localparam int DATA_W = 8;

  // Bit positions in the status word.
  localparam int ST_RXC = 7;
  localparam int ST_TXC = 6;
  localparam int ST_DRE = 5;
  localparam int ST_OVR = 3;

  typedef logic [1:0]        csize_t;
  typedef logic [DATA_W-1:0] char_t;

  // Keeps the low 5..8 bits selected by the size code.
  function automatic char_t char_mask(csize_t sz);
    return char_t'(8'hFF >> (2'd3 - sz));
  endfunction

endpackage

// File: rtl/ubuf_tx_hold.sv
module ubuf_tx_hold
  import uart_buf_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   tx_en,
  input  logic   wr_en,
  input  char_t  wr_data,
  input  csize_t char_size,
  input  logic   txs_empty,
  output logic   txs_load,
  output char_t  txs_data,
  output logic   hold_empty
);

  logic  hold_valid_q, hold_valid_d;
  char_t hold_data_q;
  logic  accept;

  assign accept   = wr_en && !hold_valid_q;
  assign txs_load = hold_valid_q && tx_en && txs_empty;

  always_comb begin
    hold_valid_d = hold_valid_q;
    if (accept)   hold_valid_d = 1'b1;
    if (txs_load) hold_valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_valid_q <= 1'b0;
    else        hold_valid_q <= hold_valid_d;
  end

  always_ff @(posedge clk) begin
    if (accept) hold_data_q <= wr_data & char_mask(char_size);
  end

  assign txs_data   = hold_data_q;
  assign hold_empty = !hold_valid_q;

  p_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hold_valid_q) |=> $stable(hold_data_q));

  p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    txs_load |=> hold_empty);

endmodule

// File: rtl/ubuf_rx_fifo.sv
module ubuf_rx_fifo
  import uart_buf_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  rx_en,
  input  logic  push,
  input  char_t push_data,
  input  logic  pop_req,
  output char_t head_data,
  output logic  not_empty,
  output logic  overrun
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [PW-1:0] rd_ptr_q, rd_ptr_d, wr_ptr_q, wr_ptr_d;
  logic [CW-1:0] count_q, count_d;
  logic          ovr_q, ovr_d;
  logic          full, empty, do_pop, do_push;
  char_t         mem [DEPTH];

  function automatic logic [PW-1:0] ptr_next(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count_q == CW'(DEPTH));
  assign empty   = (count_q == '0);
  assign do_pop  = pop_req && !empty && rx_en;
  assign do_push = push && rx_en && (!full || do_pop);

  always_comb begin
    rd_ptr_d = rd_ptr_q;
    wr_ptr_d = wr_ptr_q;
    count_d  = count_q;
    ovr_d    = ovr_q;
    if (do_pop)  rd_ptr_d = ptr_next(rd_ptr_q);
    if (do_push) wr_ptr_d = ptr_next(wr_ptr_q);
    case ({do_push, do_pop})
      2'b10:   count_d = count_q + 1'b1;
      2'b01:   count_d = count_q - 1'b1;
      default: count_d = count_q;
    endcase
    if (pop_req) ovr_d = 1'b0;
    if (push && rx_en && full && !do_pop) ovr_d = 1'b1;
    if (!rx_en) begin
      rd_ptr_d = '0;
      wr_ptr_d = '0;
      count_d  = '0;
      ovr_d    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      count_q  <= '0;
      ovr_q    <= 1'b0;
    end else begin
      rd_ptr_q <= rd_ptr_d;
      wr_ptr_q <= wr_ptr_d;
      count_q  <= count_d;
      ovr_q    <= ovr_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (do_push && (wr_ptr_q == PW'(i))) mem[i] <= push_data;
    end
  end

  assign head_data = empty ? '0 : mem[rd_ptr_q];
  assign not_empty = !empty;
  assign overrun   = ovr_q;

  p_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(DEPTH));

  p_pop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (do_pop && !do_push) |=> (count_q == $past(count_q) - 1'b1));

  p_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> empty);

  p_overrun_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (push && rx_en && full && !pop_req) |=> (overrun && full));

endmodule

// File: rtl/ubuf_flags.sv
module ubuf_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic txs_done,
  input  logic hold_empty,
  input  logic txc_clr,
  input  logic rxc,
  input  logic rxc_ie,
  input  logic txc_ie,
  input  logic dre_ie,
  output logic txc,
  output logic irq_rxc,
  output logic irq_txc,
  output logic irq_dre
);

  logic txc_q, txc_d, txc_set;

  assign txc_set = txs_done && hold_empty;

  always_comb begin
    txc_d = txc_q;
    if (txc_clr) txc_d = 1'b0;
    if (txc_set) txc_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) txc_q <= 1'b0;
    else        txc_q <= txc_d;
  end

  assign txc     = txc_q;
  assign irq_rxc = rxc && rxc_ie;
  assign irq_txc = txc_q && txc_ie;
  assign irq_dre = hold_empty && dre_ie;

  p_txc_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    txc_set |=> txc);

  p_txc_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (txc_clr && !txc_set) |=> !txc);

endmodule

// File: rtl/uart_data_buffer.sv
module uart_data_buffer
  import uart_buf_pkg::*;
#(
  parameter int RX_DEPTH = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic [1:0] char_size,
  input  logic       tx_en,
  input  logic       rx_en,
  input  logic       rxc_ie,
  input  logic       txc_ie,
  input  logic       dre_ie,
  input  logic       txc_ack,
  input  logic       txs_empty,
  input  logic       txs_done,
  output logic       txs_load,
  output logic [7:0] txs_data,
  input  logic       rx_push,
  input  logic [7:0] rx_data,
  output logic       irq_rxc,
  output logic       irq_txc,
  output logic       irq_dre
);

  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  logic  data_wr, data_rd, txc_clr;
  logic  hold_empty, rxc, txc, ovr;
  char_t head;
  logic [7:0] status;

  assign data_wr = bus_wr && !bus_addr;
  assign data_rd = bus_rd && !bus_addr;
  assign txc_clr = (bus_wr && bus_addr && bus_wdata[ST_TXC]) || txc_ack;

  ubuf_tx_hold u_tx (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .tx_en      (tx_en),
    .wr_en      (data_wr),
    .wr_data    (bus_wdata),
    .char_size  (char_size),
    .txs_empty  (txs_empty),
    .txs_load   (txs_load),
    .txs_data   (txs_data),
    .hold_empty (hold_empty)
  );

  ubuf_rx_fifo #(.DEPTH(RX_DEPTH)) u_rx (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .rx_en     (rx_en),
    .push      (rx_push),
    .push_data (rx_data),
    .pop_req   (data_rd),
    .head_data (head),
    .not_empty (rxc),
    .overrun   (ovr)
  );

  ubuf_flags u_flags (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .txs_done   (txs_done),
    .hold_empty (hold_empty),
    .txc_clr    (txc_clr),
    .rxc        (rxc),
    .rxc_ie     (rxc_ie),
    .txc_ie     (txc_ie),
    .dre_ie     (dre_ie),
    .txc        (txc),
    .irq_rxc    (irq_rxc),
    .irq_txc    (irq_txc),
    .irq_dre    (irq_dre)
  );

  always_comb begin
    status         = '0;
    status[ST_RXC] = rxc;
    status[ST_TXC] = txc;
    status[ST_DRE] = hold_empty;
    status[ST_OVR] = ovr;
  end

  assign bus_rdata = bus_addr ? status : (head & char_mask(char_size));

  p_status_quiet_r11: assert property (@(posedge clk) disable iff (!rst_i_n)
    (bus_rd && bus_addr && !bus_wr && !rx_push && !txs_done && !txc_ack
     && !txs_load && rx_en) |=> ($stable(rxc) && $stable(txc) && $stable(hold_empty)));

endmodule

// File: tb/uart_data_buffer_bench.sv
module uart_data_buffer_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_addr, bus_wr, bus_rd;
  logic [7:0] bus_wdata, bus_rdata;
  logic [1:0] char_size;
  logic       tx_en, rx_en, rxc_ie, txc_ie, dre_ie, txc_ack;
  logic       txs_empty, txs_done, txs_load;
  logic [7:0] txs_data;
  logic       rx_push;
  logic [7:0] rx_data;
  logic       irq_rxc, irq_txc, irq_dre;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  uart_data_buffer u_uart_data_buffer (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .char_size(char_size),
    .tx_en(tx_en), .rx_en(rx_en), .rxc_ie(rxc_ie), .txc_ie(txc_ie), .dre_ie(dre_ie),
    .txc_ack(txc_ack), .txs_empty(txs_empty), .txs_done(txs_done), .txs_load(txs_load),
    .txs_data(txs_data), .rx_push(rx_push), .rx_data(rx_data),
    .irq_rxc(irq_rxc), .irq_txc(irq_txc), .irq_dre(irq_dre)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic push_char(input logic [7:0] d);
    @(negedge clk);
    rx_data = d; rx_push = 1'b1;
    @(negedge clk);
    rx_push = 1'b0;
  endtask

  // op: 0 write data, 1 read data, 2 push, 3 read status, 4 set size
  localparam int NV = 20;
  localparam logic [11:0] VEC [NV] = '{
    {4'd3, 8'h20},  // R8 R11 reset status
    {4'd2, 8'hA5},
    {4'd2, 8'h3C},
    {4'd3, 8'hA0},  // R6 rxc set
    {4'd1, 8'hA5},  // R1 R2 order
    {4'd1, 8'h3C},  // R2
    {4'd3, 8'h20},  // R6 rxc clear
    {4'd1, 8'h00},  // R2 empty read
    {4'd4, 8'h00},  // size 5
    {4'd2, 8'hFF},
    {4'd1, 8'h1F},  // R3 rx mask
    {4'd4, 8'h03},  // size 8
    {4'd2, 8'h81},
    {4'd2, 8'h82},
    {4'd2, 8'h83},  // dropped
    {4'd3, 8'hA8},  // R10 overrun
    {4'd1, 8'h81},  // R10
    {4'd3, 8'hA0},  // R10 cleared
    {4'd1, 8'h82},
    {4'd1, 8'h00}   // R10 dropped char gone
  };

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; bus_addr = 0; bus_wr = 0; bus_rd = 0; bus_wdata = 0;
    char_size = 2'd3; tx_en = 1; rx_en = 1; rxc_ie = 0; txc_ie = 0; dre_ie = 0;
    txc_ack = 0; txs_empty = 0; txs_done = 0; rx_push = 0; rx_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [3:0] op;
      logic [7:0] d;
      op = VEC[i][11:8];
      d  = VEC[i][7:0];
      case (op)
        4'd0: bus_write(1'b0, d);
        4'd1: begin bus_read(1'b0, v); check($sformatf("R2 vec%0d", i), v, d); end
        4'd2: push_char(d);
        4'd3: begin bus_read(1'b1, v); check($sformatf("R11 vec%0d", i), v, d); end
        default: begin @(negedge clk); char_size = d[1:0]; end
      endcase
    end

    // R9 dre irq after reset, rxc irq with data
    dre_ie = 1; rxc_ie = 1;
    #1 check("R9 irq_dre", {7'd0, irq_dre}, 8'h01);
    check("R9 irq_rxc idle", {7'd0, irq_rxc}, 8'h00);
    push_char(8'h44);
    check("R9 irq_rxc", {7'd0, irq_rxc}, 8'h01);
    bus_read(1'b0, v);
    check("R1 read", v, 8'h44);

    // Transmit path, size 6: R3 R4 R5
    char_size = 2'd1;
    bus_write(1'b0, 8'hFF);
    bus_read(1'b1, v);
    check("R5 dre low when full", v, 8'h00);
    check("R9 irq_dre low", {7'd0, irq_dre}, 8'h00);
    bus_write(1'b0, 8'h11);                // R4 discarded
    @(negedge clk);
    txs_empty = 1'b1;
    #1 check("R5 load strobe", {7'd0, txs_load}, 8'h01);
    check("R3 R4 tx data", txs_data, 8'h3F);
    @(negedge clk);
    txs_empty = 1'b0;
    #1 check("R5 load one cycle", {7'd0, txs_load}, 8'h00);
    bus_read(1'b1, v);
    check("R5 dre after load", v, 8'h20);

    // tx disabled blocks load
    tx_en = 0;
    bus_write(1'b0, 8'h05);
    @(negedge clk); txs_empty = 1'b1;
    #1 check("R5 tx_en low no load", {7'd0, txs_load}, 8'h00);
    @(negedge clk); txs_empty = 1'b0; tx_en = 1'b1;

    // R7: done while holding full does not set txc
    @(negedge clk); txs_done = 1'b1;
    @(negedge clk); txs_done = 1'b0;
    bus_read(1'b1, v);
    check("R7 no txc while full", v, 8'h00);
    @(negedge clk); txs_empty = 1'b1;
    @(negedge clk); txs_empty = 1'b0;
    @(negedge clk); txs_done = 1'b1;
    @(negedge clk); txs_done = 1'b0;
    bus_read(1'b1, v);
    check("R7 txc set", v, 8'h60);
    txc_ie = 1;
    #1 check("R9 irq_txc", {7'd0, irq_txc}, 8'h01);
    bus_write(1'b1, 8'h40);
    bus_read(1'b1, v);
    check("R7 w1c", v, 8'h20);
    @(negedge clk); txs_done = 1'b1;
    @(negedge clk); txs_done = 1'b0;
    @(negedge clk); txc_ack = 1'b1;
    @(negedge clk); txc_ack = 1'b0;
    bus_read(1'b1, v);
    check("R7 ack clear", v, 8'h20);
    @(negedge clk); txs_done = 1'b1; txc_ack = 1'b1;
    @(negedge clk); txs_done = 1'b0; txc_ack = 1'b0;
    bus_read(1'b1, v);
    check("R7 set wins", v, 8'h60);
    bus_write(1'b1, 8'h40);

    // R6 flush on rx disable
    char_size = 2'd3;
    push_char(8'h55);
    push_char(8'h66);
    @(negedge clk); rx_en = 1'b0;
    rx_data = 8'h77; rx_push = 1'b1;
    @(negedge clk); rx_push = 1'b0;
    bus_read(1'b1, v);
    check("R6 flushed", v, 8'h20);
    rx_en = 1'b1;
    bus_read(1'b0, v);
    check("R6 push ignored", v, 8'h00);

    // R10 push and read together on full FIFO
    push_char(8'h11);
    push_char(8'h22);
    @(negedge clk);
    bus_addr = 1'b0; bus_rd = 1'b1; rx_data = 8'h33; rx_push = 1'b1;
    #1 check("R10 concurrent head", bus_rdata, 8'h11);
    @(negedge clk); bus_rd = 1'b0; rx_push = 1'b0;
    bus_read(1'b1, v);
    check("R10 no overrun", v, 8'hA0);
    bus_read(1'b0, v);
    check("R10 second", v, 8'h22);
    bus_read(1'b0, v);
    check("R10 kept push", v, 8'h33);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule